// File: doc/BRIEF.md
# Cross-Domain Soft Reset Handshake

This block turns a soft reset request into a single reset strobe in a second clock domain. The request can come from software, as a register write that sets the soft reset bit, or from a chip-wide global soft reset line. Both are sampled in the register clock domain. An accepted request flips a request toggle, which crosses into the protocol clock domain through a flip-flop synchronizer. There the change is turned into a one-cycle reset pulse. After the pulse, an acknowledge toggle returns through a matching synchronizer.

A status bit goes high on the register clock edge that accepts a request. It stays high while the handshake is in flight and drops by itself once the acknowledge has come back, so software can poll it. The pulse is fanned out to a fixed set of register groups. Mode control (except module disable), the free-running timer, the error counters, the error status, and the interrupt masks and flags are cleared. Bus timing, the receive masks and the message buffers are left untouched.

A request that arrives while the module is in low-power mode is refused. A request that arrives while one is already pending is folded into that pending request.

Top module: `softreset_xdomain`

## Requirements
- R1: While both resets are asserted and just after they are released, `pending` is 0, `soft_rst_pulse` is 0 and `grp_rst` is all zeros.
- R2: When `sw_req` is 1 on a register clock edge, `low_power` is 0 and `pending` is 0, then `pending` is 1 after that edge.
- R3: A `glb_req` pulse under the same conditions is accepted in the same way as `sw_req`. When both arrive in the same cycle, they count as one request.
- R4: Each accepted request produces exactly one `soft_rst_pulse` in the protocol domain, exactly one protocol clock cycle wide.
- R5: `grp_rst` bit positions are: 0 mode control, 1 timer, 2 error counters, 3 error status, 4 interrupt masks, 5 interrupt flags, 6 bus timing, 7 receive masks, 8 message buffers. With default parameters, bits 0 to 5 equal `soft_rst_pulse` and bits 6 to 8 stay 0.
- R6: `pending` drops by itself only after the reset pulse has been issued. It drops within 30 register clock cycles of being set (protocol clock at most twice the register clock period).
- R7: A request seen while `low_power` is 1 is ignored: `pending` stays 0 and no pulse is produced.
- R8: A request made while `pending` is 1 starts no new handshake. It produces no extra pulse, and `pending` falls only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_reg | input | 1 | Register-side clock |
| rst_reg_n | input | 1 | Active-low asynchronous reset, register domain |
| clk_prot | input | 1 | Protocol-side clock |
| rst_prot_n | input | 1 | Active-low asynchronous reset, protocol domain |
| sw_req | input | 1 | Software soft reset request (write of 1), register domain |
| glb_req | input | 1 | Chip-wide global soft reset request, register domain |
| low_power | input | 1 | Module clocks gated, register domain |
| pending | output | 1 | Self-clearing soft reset status bit |
| soft_rst_pulse | output | 1 | One-cycle reset strobe, protocol domain |
| grp_rst | output | NUM_GROUPS | Per-group reset strobes, protocol domain |

## Verification
The bench runs the two domains on unrelated clock periods. It tracks accepted requests in a behavioural model and checks every pulse for width and group pattern. A status bit that cleared on its own edge rather than waiting for the return acknowledge would drop before the pulse count caught up, and the bench reports that. A design that restarted the handshake on a second request during a pending one would show an extra pulse. One that ignored the low-power gate would raise `pending`. Coincident software and global requests are also driven, to catch a design that counts them twice.

// File: rtl/softrst_pkg.sv
package softrst_pkg;
   localparam int GRP_MODE    = 0;
   localparam int GRP_TIMER   = 1;
   localparam int GRP_ERRCNT  = 2;
   localparam int GRP_ERRSTAT = 3;
   localparam int GRP_IMASK   = 4;
   localparam int GRP_IFLAG   = 5;
   localparam int GRP_BUSTIME = 6;
   localparam int GRP_RXMASK  = 7;
   localparam int GRP_MSGBUF  = 8;
   localparam int GRP_NUM     = 9;

   localparam logic [GRP_NUM-1:0] GRP_AFFECT_DEFAULT =
      (GRP_NUM'(1) << GRP_MODE)   | (GRP_NUM'(1) << GRP_TIMER) |
      (GRP_NUM'(1) << GRP_ERRCNT) | (GRP_NUM'(1) << GRP_ERRSTAT) |
      (GRP_NUM'(1) << GRP_IMASK)  | (GRP_NUM'(1) << GRP_IFLAG);
endpackage

// File: rtl/srh_sync.sv
module srh_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("srh_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/srh_req_side.sv
module srh_req_side #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_req,
   input  logic glb_req,
   input  logic low_power,
   input  logic ack_tgl_in,
   output logic req_tgl,
   output logic pending
);
   logic ack_sync;
   logic want, accept, done;

   srh_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .d(ack_tgl_in), .q(ack_sync)
   );

   assign want   = sw_req | glb_req;
   assign accept = want & ~low_power & ~pending;
   assign done   = pending & (ack_sync == req_tgl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_tgl <= 1'b0;
         pending <= 1'b0;
      end else if (accept) begin
         req_tgl <= ~req_tgl;
         pending <= 1'b1;
      end else if (done) begin
         pending <= 1'b0;
      end
   end

   AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (want && !low_power && !pending) |=> pending); // R2
   AST_LP_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (low_power && !pending) |=> !pending); // R7
   AST_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
      pending |=> $stable(req_tgl)); // R8
endmodule

// File: rtl/srh_rst_side.sv
module srh_rst_side #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_tgl_in,
   output logic pulse,
   output logic ack_tgl
);
   logic req_sync, req_seen;

   srh_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(clk), .rst_n(rst_n), .d(req_tgl_in), .q(req_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_seen <= 1'b0;
         pulse    <= 1'b0;
         ack_tgl  <= 1'b0;
      end else begin
         req_seen <= req_sync;
         pulse    <= req_sync ^ req_seen;
         ack_tgl  <= req_seen;
      end
   end

   AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse); // R4
   AST_ACK_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_tgl != $past(ack_tgl)) |-> $past(pulse)); // R6
endmodule

// File: rtl/softreset_xdomain.sv
module softreset_xdomain #(
   parameter int                    SYNC_STAGES = 2,
   parameter int                    NUM_GROUPS  = softrst_pkg::GRP_NUM,
   parameter logic [NUM_GROUPS-1:0] AFFECT_MASK = softrst_pkg::GRP_AFFECT_DEFAULT
) (
   input  logic                  clk_reg,
   input  logic                  rst_reg_n,
   input  logic                  clk_prot,
   input  logic                  rst_prot_n,
   input  logic                  sw_req,
   input  logic                  glb_req,
   input  logic                  low_power,
   output logic                  pending,
   output logic                  soft_rst_pulse,
   output logic [NUM_GROUPS-1:0] grp_rst
);
   logic req_tgl, ack_tgl;

   generate
      if (NUM_GROUPS < 1) begin : g_bad_groups
         $error("softreset_xdomain: NUM_GROUPS must be positive");
      end
   endgenerate

   srh_req_side #(.SYNC_STAGES(SYNC_STAGES)) u_req (
      .clk(clk_reg), .rst_n(rst_reg_n), .sw_req(sw_req), .glb_req(glb_req),
      .low_power(low_power), .ack_tgl_in(ack_tgl), .req_tgl(req_tgl),
      .pending(pending)
   );

   srh_rst_side #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
      .clk(clk_prot), .rst_n(rst_prot_n), .req_tgl_in(req_tgl),
      .pulse(soft_rst_pulse), .ack_tgl(ack_tgl)
   );

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
         if (AFFECT_MASK[g]) begin : g_hit
            assign grp_rst[g] = soft_rst_pulse;
         end else begin : g_keep
            assign grp_rst[g] = 1'b0;
         end
      end
   endgenerate

   AST_GRP_QUIET: assert property (@(posedge clk_prot) disable iff (!rst_prot_n)
      !soft_rst_pulse |-> (grp_rst == '0)); // R5
endmodule

// File: tb/softreset_xdomain_tb.sv
module softreset_xdomain_tb;
   localparam int CLK_PERIOD  = 10;
   localparam int PROT_PERIOD = 17;
   localparam logic [8:0] EXP_MASK = 9'b000111111;

   logic clk_reg = 0, clk_prot = 0;
   logic rst_reg_n = 0, rst_prot_n = 0;
   logic sw_req = 0, glb_req = 0, low_power = 0;
   logic pending, soft_rst_pulse;
   logic [8:0] grp_rst;

   int checks = 0, errors = 0;
   int pulses = 0, accepted = 0, wait_cnt = 0;
   bit mdl_pend = 0, prev_pulse = 0, done = 0;

   always #(CLK_PERIOD/2)  clk_reg  = ~clk_reg;
   always #(PROT_PERIOD/2) clk_prot = ~clk_prot;

   softreset_xdomain u_dut (
      .clk_reg(clk_reg), .rst_reg_n(rst_reg_n), .clk_prot(clk_prot),
      .rst_prot_n(rst_prot_n), .sw_req(sw_req), .glb_req(glb_req),
      .low_power(low_power), .pending(pending),
      .soft_rst_pulse(soft_rst_pulse), .grp_rst(grp_rst)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // reference model: acceptance in the register domain
   always @(posedge clk_reg) begin
      if (rst_reg_n && !mdl_pend && (sw_req || glb_req) && !low_power) begin
         mdl_pend = 1;
         accepted++;
         wait_cnt = 0;
      end
   end

   // register-domain comparison every cycle
   always @(negedge clk_reg) begin
      if (rst_reg_n && rst_prot_n) begin
         if (mdl_pend) begin
            if (pending) begin
               wait_cnt++;
               check(wait_cnt <= 30, "R6", "pending stuck", wait_cnt, 30);
               if (wait_cnt > 30) mdl_pend = 0;
            end else begin
               check(pulses == accepted, "R6", "pending cleared before pulse", pulses, accepted);
               mdl_pend = 0;
            end
         end else begin
            check(pending == 0, "R2", "pending without accepted request", pending, 0);
         end
      end
   end

   // protocol-domain pulse monitor
   always @(negedge clk_prot) begin
      if (rst_prot_n) begin
         if (soft_rst_pulse) begin
            pulses++;
            check(!prev_pulse, "R4", "pulse wider than one cycle", 2, 1);
            check(grp_rst == EXP_MASK, "R5", "group pattern", grp_rst, EXP_MASK);
         end else begin
            check(grp_rst == 0, "R5", "groups active without pulse", grp_rst, 0);
         end
         prev_pulse = soft_rst_pulse;
      end
   end

   task automatic req(input bit s, input bit g);
      @(negedge clk_reg);
      sw_req = s; glb_req = g;
      @(negedge clk_reg);
      sw_req = 0; glb_req = 0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 80; i++) begin
         @(negedge clk_reg);
         if (!pending && !mdl_pend) break;
      end
      repeat (6) @(negedge clk_reg);
   endtask

   initial begin
      #(CLK_PERIOD*150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int base;
      repeat (3) @(negedge clk_reg);
      // R1 reset state
      check(pending == 0 && soft_rst_pulse == 0 && grp_rst == 0, "R1", "outputs in reset",
            {pending, soft_rst_pulse}, 0);
      rst_reg_n = 1; rst_prot_n = 1;
      repeat (4) @(negedge clk_reg);
      check(pending == 0 && grp_rst == 0, "R1", "outputs after reset", pending, 0);

      // R2 software request
      base = pulses;
      req(1, 0);
      check(pending == 1, "R2", "pending after sw request", pending, 1);
      wait_idle();
      check(pulses - base == 1, "R4", "pulses for one sw request", pulses - base, 1);

      // R3 global request
      base = pulses;
      req(0, 1);
      check(pending == 1, "R3", "pending after global request", pending, 1);
      wait_idle();
      check(pulses - base == 1, "R3", "pulses for global request", pulses - base, 1);

      // R3 coincident sources
      base = pulses;
      req(1, 1);
      wait_idle();
      check(pulses - base == 1, "R3", "coincident requests", pulses - base, 1);

      // R7 low power refuses
      base = pulses;
      @(negedge clk_reg); low_power = 1;
      req(1, 0);
      check(pending == 0, "R7", "pending during low power", pending, 0);
      req(0, 1);
      repeat (30) @(negedge clk_reg);
      check(pending == 0, "R7", "pending later in low power", pending, 0);
      check(pulses == base, "R7", "pulses in low power", pulses - base, 0);
      low_power = 0;
      repeat (4) @(negedge clk_reg);
      check(pulses == base && pending == 0, "R7", "no late effect", pulses - base, 0);

      // R8 merge while pending
      base = pulses;
      req(1, 0);
      repeat (2) @(negedge clk_reg);
      check(pending == 1, "R8", "still pending", pending, 1);
      req(0, 1);
      req(1, 0);
      wait_idle();
      check(pulses - base == 1, "R8", "merged requests", pulses - base, 1);

      // R6 stream of requests at mixed gaps
      base = pulses;
      for (int k = 0; k < 20; k++) begin
         req(k[0], k[1] | ~k[0]);
         repeat ((k * 7) % 23) @(negedge clk_reg);
      end
      wait_idle();
      check(pulses == accepted, "R6", "total pulses vs accepted", pulses, accepted);
      check(pulses - base >= 5, "R4", "stream produced pulses", pulses - base, 5);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule